// File: doc/BRIEF.md
# Dual-Precision Floating-Point Rounder

This block takes a floating-point result that arms have computed beyond the target width and brings it back to a representable value. The input is a sign, a biased exponent and a 40-bit significand. The significand is left-aligned with its hidden bit at bit 39, and every bit below the target width is treated as discarded. Each operation selects one of two target precisions: single (24 kept bits) or single-extended (32 kept bits). It also selects one of the four IEEE rounding directions.

The rounded significand is always returned left-aligned in a 32-bit field. A single-precision result therefore occupies the upper 24 bits, and the lower 8 bits are zero. If the increment overflows the kept field, the significand becomes a lone leading one and the exponent grows by one. An inexact flag reports any lost information. The rounding logic is combinational. An optional output register, present by default, captures a result on each cycle where `valid_i` is high.

Top module: `fp_round_unit`

## Requirements
- R1: With `mode_i` = 00 (nearest, ties to even), the kept field is incremented when the guard bit is 1 and either the sticky bit or the kept LSB is 1; otherwise it is truncated.
- R2: With `mode_i` = 01 (toward zero), the result is always the truncated kept field, for either sign, and the exponent is unchanged.
- R3: With `mode_i` = 10 (toward +inf), a positive inexact value (`sign_i` = 0) is incremented and a negative value is truncated.
- R4: With `mode_i` = 11 (toward -inf), a negative inexact value (`sign_i` = 1) is incremented and a positive value is truncated.
- R5: With `prec_i` = 0 (single), the kept field is `sig_i[39:16]` and the guard bit is `sig_i[15]`. Sticky is the OR of `sig_i[14:0]`. The result appears in `sig_o[31:8]`, and `sig_o[7:0]` is zero.
- R6: With `prec_i` = 1 (extended), the kept field is `sig_i[39:8]` and the guard bit is `sig_i[7]`. Sticky is the OR of `sig_i[6:0]`. The result appears in `sig_o[31:0]`.
- R7: When the increment carries out of the kept field, `sig_o` holds 1 in bit 31 and zero elsewhere, and `exp_o` = `exp_i` + 1 (modulo 2^15).
- R8: `inexact_o` is 1 exactly when some discarded bit for the selected precision is 1, independent of the mode.
- R9: An input with no discarded bit set is returned unchanged (kept field, exponent) in every mode.
- R10: A result is due one cycle after the clock edge that samples `valid_i` = 1, with `valid_o` high. While `valid_i` is low, `valid_o` falls and the other outputs hold. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operand valid, enables the output stage |
| sign_i | input | 1 | Sign of the unrounded value (1 = negative) |
| exp_i | input | 15 | Exponent of the unrounded value |
| sig_i | input | 40 | Left-aligned unrounded significand |
| mode_i | input | 2 | Rounding direction: 00 nearest-even, 01 zero, 10 +inf, 11 -inf |
| prec_i | input | 1 | Target precision: 0 single, 1 extended |
| valid_o | output | 1 | Result valid |
| sig_o | output | 32 | Rounded significand, left-aligned |
| exp_o | output | 15 | Exponent after carry adjustment |
| inexact_o | output | 1 | Some discarded bit was nonzero |

## Verification
Every rounded field and the inexact flag is due in the cycle after the rising edge that samples `valid_i` high. The driver applies operands one time unit after a rising edge. On each such application it pushes the expected significand, exponent and flag, derived from the rounding rules, into a queue. A monitor looks at the outputs on falling edges, and only when `valid_o` is high. It pops one entry per result, so the one-cycle latency and the ordering are checked together. The hold behaviour is checked on falling edges while `valid_i` stays low and the inputs are changed.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_ZERO = 2'b01,
    RND_POS  = 2'b10,
    RND_NEG  = 2'b11
  } rnd_mode_e;

  localparam int unsigned EXP_W    = 15;
  localparam int unsigned SIG_IN_W = 40;
  localparam int unsigned SP_KEEP  = 24;
  localparam int unsigned XP_KEEP  = 32;
endpackage

// File: rtl/fpr_split.sv
// Cuts a left-aligned significand into kept field, guard and sticky.
module fpr_split #(
  parameter int unsigned SIG_IN_W = 40,
  parameter int unsigned KEEP_W   = 24
) (
  input  logic [SIG_IN_W-1:0] sig_i,
  output logic [KEEP_W-1:0]   kept_o,
  output logic                guard_o,
  output logic                sticky_o
);
  localparam int unsigned DROP_W = SIG_IN_W - KEEP_W;

  logic [DROP_W-1:0] drop;

  assign kept_o   = sig_i[SIG_IN_W-1 -: KEEP_W];
  assign drop     = sig_i[DROP_W-1:0];
  assign guard_o  = drop[DROP_W-1];
  assign sticky_o = |drop[DROP_W-2:0];
endmodule

// File: rtl/fpr_decide.sv
// Rounding direction decision.
module fpr_decide
  import fpr_pkg::*;
(
  input  rnd_mode_e mode_i,
  input  logic      sign_i,
  input  logic      lsb_i,
  input  logic      guard_i,
  input  logic      sticky_i,
  output logic      inc_o,
  output logic      inexact_o
);
  logic lost;

  assign lost      = guard_i | sticky_i;
  assign inexact_o = lost;

  always_comb begin
    unique case (mode_i)
      RND_NEAR: inc_o = guard_i & (sticky_i | lsb_i);
      RND_ZERO: inc_o = 1'b0;
      RND_POS:  inc_o = lost & ~sign_i;
      RND_NEG:  inc_o = lost &  sign_i;
      default:  inc_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpr_incr.sv
// Shared incrementer on the left-aligned field; step sits at the kept LSB.
module fpr_incr #(
  parameter int unsigned OUT_W = 32,
  parameter int unsigned PAD_W = 8,
  parameter int unsigned EXP_W = 15
) (
  input  logic [OUT_W-1:0] kept_i,
  input  logic             narrow_i,
  input  logic             inc_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic [OUT_W-1:0] sig_o,
  output logic [EXP_W-1:0] exp_o
);
  logic [OUT_W:0] step;
  logic [OUT_W:0] sum;
  logic           carry;

  always_comb begin
    step = '0;
    if (inc_i) begin
      if (narrow_i) step[PAD_W] = 1'b1;
      else          step[0]     = 1'b1;
    end
  end

  assign sum   = {1'b0, kept_i} + step;
  assign carry = sum[OUT_W];
  // all-ones kept field wraps to zero; renormalise to a single leading one
  assign sig_o = carry ? {1'b1, {(OUT_W-1){1'b0}}} : sum[OUT_W-1:0];
  assign exp_o = exp_i + EXP_W'(carry);
endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
  import fpr_pkg::*;
#(
  parameter int unsigned EXP_WIDTH = EXP_W,
  parameter int unsigned SIG_WIDTH = SIG_IN_W,
  parameter int unsigned SP_W      = SP_KEEP,
  parameter int unsigned XP_W      = XP_KEEP,
  parameter bit          OUT_REG   = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 sign_i,
  input  logic [EXP_WIDTH-1:0] exp_i,
  input  logic [SIG_WIDTH-1:0] sig_i,
  input  logic [1:0]           mode_i,
  input  logic                 prec_i,
  output logic                 valid_o,
  output logic [XP_W-1:0]      sig_o,
  output logic [EXP_WIDTH-1:0] exp_o,
  output logic                 inexact_o
);
  localparam int unsigned PAD_W = XP_W - SP_W;

  logic [SP_W-1:0]      sp_kept;
  logic                 sp_guard, sp_sticky;
  logic [XP_W-1:0]      xp_kept;
  logic                 xp_guard, xp_sticky;
  logic [XP_W-1:0]      kept_al;
  logic                 guard, sticky, lsb, inc, inexact;
  logic [XP_W-1:0]      sig_rnd;
  logic [EXP_WIDTH-1:0] exp_rnd;
  rnd_mode_e            mode;

  assign mode = rnd_mode_e'(mode_i);

  fpr_split #(.SIG_IN_W(SIG_WIDTH), .KEEP_W(SP_W)) i_split_sp (
    .sig_i(sig_i), .kept_o(sp_kept), .guard_o(sp_guard), .sticky_o(sp_sticky)
  );

  fpr_split #(.SIG_IN_W(SIG_WIDTH), .KEEP_W(XP_W)) i_split_xp (
    .sig_i(sig_i), .kept_o(xp_kept), .guard_o(xp_guard), .sticky_o(xp_sticky)
  );

  always_comb begin
    if (prec_i) begin
      kept_al = xp_kept;
      guard   = xp_guard;
      sticky  = xp_sticky;
      lsb     = xp_kept[0];
    end else begin
      kept_al = {sp_kept, {PAD_W{1'b0}}};
      guard   = sp_guard;
      sticky  = sp_sticky;
      lsb     = sp_kept[0];
    end
  end

  fpr_decide i_decide (
    .mode_i(mode), .sign_i(sign_i), .lsb_i(lsb), .guard_i(guard),
    .sticky_i(sticky), .inc_o(inc), .inexact_o(inexact)
  );

  fpr_incr #(.OUT_W(XP_W), .PAD_W(PAD_W), .EXP_W(EXP_WIDTH)) i_incr (
    .kept_i(kept_al), .narrow_i(~prec_i), .inc_i(inc), .exp_i(exp_i),
    .sig_o(sig_rnd), .exp_o(exp_rnd)
  );

  generate
    if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          valid_o   <= 1'b0;
          sig_o     <= '0;
          exp_o     <= '0;
          inexact_o <= 1'b0;
        end else begin
          valid_o <= valid_i;
          if (valid_i) begin
            sig_o     <= sig_rnd;
            exp_o     <= exp_rnd;
            inexact_o <= inexact;
          end
        end
      end

      AST_ZERO_KEEPS_EXP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o && $past(mode_i) == 2'b01 |-> exp_o == $past(exp_i)); // R2
      AST_SP_LOW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o && !$past(prec_i) |-> sig_o[PAD_W-1:0] == '0); // R5
      AST_CARRY_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o && exp_o != $past(exp_i) |-> sig_o == {1'b1, {(XP_W-1){1'b0}}}); // R7
      AST_EXACT_UNCHANGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o && !inexact_o |-> exp_o == $past(exp_i)); // R9
      AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !valid_o && $stable(sig_o) && $stable(exp_o)); // R10
    end else begin : g_comb
      assign valid_o   = valid_i;
      assign sig_o     = sig_rnd;
      assign exp_o     = exp_rnd;
      assign inexact_o = inexact;
    end
  endgenerate
endmodule

// File: tb/test_fp_round_unit.sv
module test_fp_round_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        sign_i = 1'b0;
  logic [14:0] exp_i = '0;
  logic [39:0] sig_i = '0;
  logic [1:0]  mode_i = '0;
  logic        prec_i = 1'b0;
  logic        valid_o;
  logic [31:0] sig_o;
  logic [14:0] exp_o;
  logic        inexact_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] sig;
    logic [14:0] exp;
    logic        inx;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;

  fp_round_unit i_fp_round_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .sign_i(sign_i),
    .exp_i(exp_i), .sig_i(sig_i), .mode_i(mode_i), .prec_i(prec_i),
    .valid_o(valid_o), .sig_o(sig_o), .exp_o(exp_o), .inexact_o(inexact_o)
  );

  function automatic exp_t model(input logic s, input logic [14:0] e,
                                 input logic [39:0] m, input logic [1:0] md,
                                 input logic p);
    exp_t r;
    logic [31:0] k;
    logic g, st, up;
    logic [32:0] sum;
    if (p) begin
      k = m[39:8]; g = m[7]; st = |m[6:0];                // R6
    end else begin
      k = {8'h00, m[39:16]}; g = m[15]; st = |m[14:0];    // R5
    end
    case (md)
      2'b00: up = g & (st | k[0]);   // R1
      2'b01: up = 1'b0;              // R2
      2'b10: up = (g | st) & ~s;     // R3
      default: up = (g | st) & s;    // R4
    endcase
    sum = {1'b0, k} + 33'(up);
    r.inx = g | st;                  // R8
    r.exp = e;
    if (p) begin
      if (sum[32]) begin r.sig = 32'h8000_0000; r.exp = e + 15'd1; end // R7
      else r.sig = sum[31:0];
    end else begin
      if (sum[24]) begin r.sig = 32'h8000_0000; r.exp = e + 15'd1; end // R7
      else r.sig = {sum[23:0], 8'h00};
    end
    r.tag = "";
    return r;
  endfunction

  task automatic drive(input logic s, input logic [14:0] e, input logic [39:0] m,
                       input logic [1:0] md, input logic p, input string tag);
    exp_t x;
    @(posedge clk);
    #1;
    valid_i = 1'b1; sign_i = s; exp_i = e; sig_i = m; mode_i = md; prec_i = p;
    x = model(s, e, m, md, p);
    x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic idle();
    @(posedge clk);
    #1;
    valid_i = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && valid_o && !done) begin
      exp_t x;
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R10: result with nothing expected sig=%h", sig_o);
      end else begin
        x = sb.pop_front();
        if (sig_o !== x.sig || exp_o !== x.exp || inexact_o !== x.inx) begin
          n_bad++;
          $display("FAIL %s: sig=%h exp=%h inx=%b expected sig=%h exp=%h inx=%b",
                   x.tag, sig_o, exp_o, inexact_o, x.sig, x.exp, x.inx);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held_sig;
    logic [14:0] held_exp;
    repeat (3) @(negedge clk);
    n_chk++;
    if (valid_o !== 1'b0 || sig_o !== '0 || exp_o !== '0 || inexact_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R10: reset state sig=%h exp=%h v=%b expected zeros", sig_o, exp_o, valid_o);
    end
    rst_n = 1'b1;

    // R1 nearest-even, extended cut
    drive(0, 15'd100, {32'h0000_0010, 8'h80}, 2'b00, 1, "R1 tie even");
    drive(0, 15'd100, {32'h0000_0011, 8'h80}, 2'b00, 1, "R1 tie odd");
    drive(1, 15'd100, {32'h0000_0010, 8'h81}, 2'b00, 1, "R1 above half");
    drive(0, 15'd100, {32'h0000_0011, 8'h7F}, 2'b00, 1, "R1 below half");
    // R2 toward zero
    drive(1, 15'd7, {32'h1234_5677, 8'hFF}, 2'b01, 1, "R2 neg");
    drive(0, 15'd7, {32'h1234_5677, 8'hFF}, 2'b01, 1, "R2 pos");
    // R3 toward +inf
    drive(0, 15'd9, {32'h8000_0000, 8'h01}, 2'b10, 1, "R3 pos inexact");
    drive(1, 15'd9, {32'h8000_0000, 8'h01}, 2'b10, 1, "R3 neg truncates");
    // R4 toward -inf
    drive(1, 15'd9, {32'h8000_0000, 8'h40}, 2'b11, 1, "R4 neg inexact");
    drive(0, 15'd9, {32'h8000_0000, 8'h40}, 2'b11, 1, "R4 pos truncates");
    // R5/R6 cut position: bit 9 is discarded for single, kept for extended
    drive(0, 15'd3, 40'h80_0000_0200, 2'b10, 0, "R5 single sticky");
    drive(0, 15'd3, 40'h80_0000_0200, 2'b10, 1, "R6 extended exact");
    drive(0, 15'd3, 40'h80_0001_8000, 2'b00, 0, "R5 single tie odd");
    // R7 carry out
    drive(0, 15'd20, {32'hFFFF_FFFF, 8'h80}, 2'b00, 1, "R7 extended carry");
    drive(1, 15'h7FFF, {24'hFF_FFFF, 16'h0001}, 2'b11, 0, "R7 single carry wrap");
    // R8 inexact in every mode, R9 exact input unchanged
    for (int md = 0; md < 4; md++) begin
      drive(1, 15'd55, {32'hABCD_EF01, 8'h00}, 2'(md), 1, "R9 exact extended");
      drive(0, 15'd55, {24'hABCDEF, 16'h0000}, 2'(md), 0, "R9 exact single");
      drive(0, 15'd55, {24'hABCDEF, 16'h0100}, 2'(md), 0, "R8 inexact sticky");
    end
    // mixed sweep
    for (int i = 0; i < 400; i++) begin
      logic [39:0] m;
      m = {$urandom(), 8'($urandom())};
      m[39] = 1'b1;
      drive(1'($urandom()), 15'($urandom()), m, 2'($urandom()), 1'($urandom()),
            "R1 R2 R3 R4 R5 R6 R8 sweep");
    end
    idle();
    repeat (3) @(posedge clk);

    // R10 hold while idle with changing inputs
    @(negedge clk);
    held_sig = sig_o;
    held_exp = exp_o;
    for (int j = 0; j < 3; j++) begin
      @(posedge clk);
      #1;
      sig_i = {$urandom(), 8'($urandom())} | 40'h80_0000_00FF;
      exp_i = 15'($urandom());
      mode_i = 2'($urandom());
      @(negedge clk);
      n_chk++;
      if (valid_o !== 1'b0 || sig_o !== held_sig || exp_o !== held_exp) begin
        n_bad++;
        $display("FAIL R10: idle v=%b sig=%h exp=%h expected v=0 sig=%h exp=%h",
                 valid_o, sig_o, exp_o, held_sig, held_exp);
      end
    end

    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R10: %0d results missing, expected 0", sb.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule